// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits in a processor core and runs the busy-wait handshake between the core and an external coprocessor. It covers five instruction classes: moving a coprocessor value into a core register, moving a core register value into the coprocessor, a coprocessor-internal data operation, loading memory words into the coprocessor, and storing coprocessor words to memory. Each cycle the sequencer presents a phase code to the coprocessor and samples a two-bit response code in the same cycle. While the coprocessor reports busy, the sequencer inserts idle cycles and checks for pending interrupts. A pending interrupt abandons the instruction. For loads and stores it walks word addresses upward for as long as the coprocessor asks for more words.

An instruction is started by a one-cycle `start` pulse with the class code and base address. The sequencer ends every instruction with a one-cycle `done` pulse and a status code: completed, undefined-instruction trap, coprocessor abort, internal address abort, memory abort, or abandoned for an interrupt. When the instruction is abandoned, it also gives the winning exception.

States: IDLE (waiting for `start`), FIRST (phase FIRST, response sampled), WAIT (idle cycle, interrupts checked), BUSY (phase BUSY, response sampled), CCYC (coprocessor register cycle), ICYC (trailing idle cycle of a transfer into the core), XFER (phase TRANSFER ahead of a load), LMEM (memory read), LDATA (phase DATA for a loaded word), SDATA (phase DATA plus memory write), INTR (phase INTERRUPT) and REPORT (`done` high). The transitions are as follows:
- IDLE goes to FIRST on an accepted start, and to REPORT on an illegal class or an address fault.
- FIRST and BUSY go to WAIT on BUSY. They go to REPORT on CANT or when the watchdog expires. On DONE or INC they go to CCYC, XFER, SDATA or REPORT, depending on the class.
- WAIT goes to INTR if an interrupt is pending, and to BUSY otherwise.
- CCYC goes to ICYC for a transfer into the core, and to REPORT otherwise. ICYC goes to REPORT.
- XFER goes to LMEM, and LMEM goes to LDATA. LDATA goes to LMEM on INC and to REPORT otherwise.
- SDATA stays in SDATA on INC and goes to REPORT otherwise.
- INTR goes to REPORT, and REPORT goes to IDLE.

Top module: `cp_handshake_seq`

## Requirements
- R1: After reset the phase output is IDLE, and `done`, `busy`, `mem_req` and `mem_we` are low. The phase codes are IDLE=0, FIRST=1, BUSY=2, INTERRUPT=3, TRANSFER=4 and DATA=5.
- R2: An accepted `start` (class 0 to 4, no address fault) makes the next cycle issue FIRST. A `start` while `busy` is high is ignored. The class codes are: 0 coprocessor to core register, 1 core register to coprocessor, 2 data operation, 3 load, 4 store.
- R3: The response codes are DONE=0, BUSY=1, INC=2 and CANT=3. A BUSY response to FIRST or BUSY causes one idle cycle (`idle_cycle` high, phase IDLE) and then a reissued BUSY phase.
- R4: If an interrupt is pending in the idle cycle of a busy wait, the next cycle issues INTERRUPT. The instruction then ends with status ABANDON=5 and no trap. A pending interrupt has no effect on an instruction that never waits.
- R5: The exception code is RESET=1 when a reset is requested. Otherwise it is FIQ=2 when the fast interrupt is requested and not masked. Otherwise it is IRQ=3 when the normal interrupt is requested and not masked. A masked request does not abandon the wait.
- R6: A CANT response ends classes 0 to 2 with UNDEF=1, and ends loads and stores with CP_ABORT=2. No coprocessor cycle and no memory access follow.
- R7: A load or store with `addr_fault` high ends with INT_ABORT=3 and no FIRST phase. A store whose base address lies below `VEC_LIMIT` also ends this way. A load from that area and a store at exactly `VEC_LIMIT` proceed.
- R8: After the handshake, a load issues TRANSFER once. Each word is then read at the current address and followed by a DATA phase. Each INC response adds 4 to the address and reads another word.
- R9: A store issues one DATA phase per word, with a memory write at the current address in the same cycle. Each INC response adds 4 to the address.
- R10: A successful transfer into the core costs one coprocessor cycle and one idle cycle. A transfer into the coprocessor costs one coprocessor cycle. A data operation costs neither. None of these classes touches memory.
- R11: The `BUSY_LIMIT`-th consecutive BUSY response (default 1024) ends the instruction with UNDEF. One response fewer still lets it complete normally.
- R12: A memory abort on any word of a load or store is latched. The transfer runs to its end, and the instruction then ends with MEM_ABORT=4.
- R13: Class codes 5 to 7 end with UNDEF without issuing FIRST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (pulse) |
| op_class | input | 3 | Instruction class code |
| base_addr | input | AW | First word address for load/store |
| addr_fault | input | 1 | Base address failed the address check |
| cp_phase | output | 3 | Phase code issued to the coprocessor |
| cp_resp | input | 2 | Response code from the coprocessor |
| reset_req | input | 1 | Reset exception pending |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt disabled |
| irq_req | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt disabled |
| mem_req | output | 1 | Memory word access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address of the access |
| mem_abort | input | 1 | Memory reports an abort for this access |
| idle_cycle | output | 1 | Core spends an idle cycle |
| cp_cycle | output | 1 | Coprocessor register transfer cycle |
| busy | output | 1 | Sequencer is working on an instruction |
| done | output | 1 | Instruction finished (one cycle) |
| status | output | 3 | Result code, valid with `done` |
| exc_code | output | 2 | Winning exception, valid with ABANDON |

## Verification
The hardest state to reach from the ports is the watchdog edge, which needs over a thousand consecutive BUSY responses. The bench's coprocessor model is told how many BUSY answers to give before DONE. It runs once with one fewer than the limit and once with more, and counts the BUSY phases actually issued. A second hard case is a stray `start` arriving mid-wait. The run task can raise `start` with a store class at a chosen cycle inside the busy wait. The bench then confirms that no write and no second FIRST appear.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

    localparam logic [2:0] PH_IDLE  = 3'd0;
    localparam logic [2:0] PH_FIRST = 3'd1;
    localparam logic [2:0] PH_BUSY  = 3'd2;
    localparam logic [2:0] PH_INTR  = 3'd3;
    localparam logic [2:0] PH_XFER  = 3'd4;
    localparam logic [2:0] PH_DATA  = 3'd5;

    localparam logic [1:0] RSP_DONE = 2'd0;
    localparam logic [1:0] RSP_BUSY = 2'd1;
    localparam logic [1:0] RSP_INC  = 2'd2;
    localparam logic [1:0] RSP_CANT = 2'd3;

    localparam logic [2:0] OP_TO_CORE = 3'd0;
    localparam logic [2:0] OP_TO_CP   = 3'd1;
    localparam logic [2:0] OP_DATA    = 3'd2;
    localparam logic [2:0] OP_LOAD    = 3'd3;
    localparam logic [2:0] OP_STORE   = 3'd4;

    localparam logic [2:0] ST_OK        = 3'd0;
    localparam logic [2:0] ST_UNDEF     = 3'd1;
    localparam logic [2:0] ST_CP_ABORT  = 3'd2;
    localparam logic [2:0] ST_INT_ABORT = 3'd3;
    localparam logic [2:0] ST_MEM_ABORT = 3'd4;
    localparam logic [2:0] ST_ABANDON   = 3'd5;

    localparam logic [1:0] EXC_NONE  = 2'd0;
    localparam logic [1:0] EXC_RESET = 2'd1;
    localparam logic [1:0] EXC_FIQ   = 2'd2;
    localparam logic [1:0] EXC_IRQ   = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_CCYC, S_ICYC,
        S_XFER, S_LMEM, S_LDATA, S_SDATA, S_INTR, S_REPORT
    } seq_state_e;

endpackage

// File: rtl/cphs_exc_prio.sv
module cphs_exc_prio
    import cphs_pkg::*;
(
    input  logic       reset_req,
    input  logic       fiq_req,
    input  logic       fiq_mask,
    input  logic       irq_req,
    input  logic       irq_mask,
    output logic       pending,
    output logic [1:0] code
);
    always_comb begin
        if (reset_req)                 code = EXC_RESET;
        else if (fiq_req && !fiq_mask) code = EXC_FIQ;
        else if (irq_req && !irq_mask) code = EXC_IRQ;
        else                           code = EXC_NONE;
        pending = (code != EXC_NONE);
    end
endmodule

// File: rtl/cphs_addr_walker.sv
module cphs_addr_walker #(
    parameter int AW        = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          access,
    input  logic          mem_abort,
    output logic [AW-1:0] addr,
    output logic          abort_seen
);
    localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr       <= '0;
            abort_seen <= 1'b0;
        end else begin
            if (load)      addr <= base;
            else if (step) addr <= addr + STRIDE;

            if (load)                     abort_seen <= 1'b0;
            else if (access && mem_abort) abort_seen <= 1'b1;
        end
    end

    assert_word_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr == $past(addr) + STRIDE);

    assert_abort_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_seen && !load) |=> abort_seen);
endmodule

// File: rtl/cphs_busy_watch.sv
module cphs_busy_watch #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic busy_seen,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count;

    assign expire = busy_seen && (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (clr)                  count <= '0;
        else if (busy_seen && !expire) count <= count + 1'b1;
    end

    assert_count_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_seen && !expire && !clr) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
    import cphs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BUSY_LIMIT = 1024,
    parameter int VEC_LIMIT  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_class,
    input  logic [AW-1:0] base_addr,
    input  logic          addr_fault,
    output logic [2:0]    cp_phase,
    input  logic [1:0]    cp_resp,
    input  logic          reset_req,
    input  logic          fiq_req,
    input  logic          fiq_mask,
    input  logic          irq_req,
    input  logic          irq_mask,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_abort,
    output logic          idle_cycle,
    output logic          cp_cycle,
    output logic          busy,
    output logic          done,
    output logic [2:0]    status,
    output logic [1:0]    exc_code
);
    localparam logic [AW-1:0] VEC_TOP = AW'(VEC_LIMIT);

    seq_state_e state, nxt;
    logic [2:0] op_q;
    logic [2:0] status_q, nxt_status;
    logic [1:0] exc_q;

    logic accept, op_legal, is_ldst_in, int_fault, is_ldst_q;
    logic step, wd_seen, wd_expire, abort_seen;
    logic exc_pending;
    logic [1:0] exc_now;

    assign accept     = (state == S_IDLE) && start;
    assign op_legal   = (op_class <= OP_STORE);
    assign is_ldst_in = (op_class == OP_LOAD) || (op_class == OP_STORE);
    assign int_fault  = is_ldst_in &&
                        (addr_fault || ((op_class == OP_STORE) && (base_addr < VEC_TOP)));
    assign is_ldst_q  = (op_q == OP_LOAD) || (op_q == OP_STORE);

    cphs_exc_prio u_prio (
        .reset_req (reset_req),
        .fiq_req   (fiq_req),
        .fiq_mask  (fiq_mask),
        .irq_req   (irq_req),
        .irq_mask  (irq_mask),
        .pending   (exc_pending),
        .code      (exc_now)
    );

    cphs_addr_walker #(.AW(AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .base       (base_addr),
        .step       (step),
        .access     (mem_req),
        .mem_abort  (mem_abort),
        .addr       (mem_addr),
        .abort_seen (abort_seen)
    );

    cphs_busy_watch #(.LIMIT(BUSY_LIMIT)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .busy_seen (wd_seen),
        .expire    (wd_expire)
    );

    // next-state and result selection
    always_comb begin
        nxt        = state;
        nxt_status = status_q;
        step       = 1'b0;
        wd_seen    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!op_legal) begin
                        nxt = S_REPORT;  nxt_status = ST_UNDEF;
                    end else if (int_fault) begin
                        nxt = S_REPORT;  nxt_status = ST_INT_ABORT;
                    end else begin
                        nxt = S_FIRST;   nxt_status = ST_OK;
                    end
                end
            end
            S_FIRST, S_BUSY: begin
                if (cp_resp == RSP_CANT) begin
                    nxt        = S_REPORT;
                    nxt_status = is_ldst_q ? ST_CP_ABORT : ST_UNDEF;
                end else if (cp_resp == RSP_BUSY) begin
                    wd_seen = 1'b1;
                    if (wd_expire) begin
                        nxt = S_REPORT;  nxt_status = ST_UNDEF;
                    end else begin
                        nxt = S_WAIT;
                    end
                end else begin
                    case (op_q)
                        OP_TO_CORE, OP_TO_CP: nxt = S_CCYC;
                        OP_LOAD:              nxt = S_XFER;
                        OP_STORE:             nxt = S_SDATA;
                        default:              nxt = S_REPORT;
                    endcase
                end
            end
            S_WAIT:  nxt = exc_pending ? S_INTR : S_BUSY;
            S_CCYC:  nxt = (op_q == OP_TO_CORE) ? S_ICYC : S_REPORT;
            S_ICYC:  nxt = S_REPORT;
            S_XFER:  nxt = S_LMEM;
            S_LMEM:  nxt = S_LDATA;
            S_LDATA: begin
                if (cp_resp == RSP_INC) begin
                    step = 1'b1;
                    nxt  = S_LMEM;
                end else begin
                    nxt        = S_REPORT;
                    nxt_status = abort_seen ? ST_MEM_ABORT : ST_OK;
                end
            end
            S_SDATA: begin
                if (cp_resp == RSP_INC) begin
                    step = 1'b1;
                end else begin
                    nxt        = S_REPORT;
                    nxt_status = (abort_seen || mem_abort) ? ST_MEM_ABORT : ST_OK;
                end
            end
            S_INTR: begin
                nxt        = S_REPORT;
                nxt_status = ST_ABANDON;
            end
            S_REPORT: nxt = S_IDLE;
        endcase
    end

    // state register and latched instruction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_TO_CORE;
            status_q <= ST_OK;
            exc_q    <= EXC_NONE;
        end else begin
            state    <= nxt;
            status_q <= nxt_status;
            if (accept) begin
                op_q  <= op_class;
                exc_q <= EXC_NONE;
            end else if (state == S_WAIT && exc_pending) begin
                exc_q <= exc_now;
            end
        end
    end

    // Moore outputs
    always_comb begin
        cp_phase   = PH_IDLE;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        idle_cycle = 1'b0;
        cp_cycle   = 1'b0;
        unique case (state)
            S_FIRST: cp_phase = PH_FIRST;
            S_BUSY:  cp_phase = PH_BUSY;
            S_INTR:  cp_phase = PH_INTR;
            S_XFER:  cp_phase = PH_XFER;
            S_LDATA: cp_phase = PH_DATA;
            S_SDATA: begin
                cp_phase = PH_DATA;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
            end
            S_LMEM:  mem_req    = 1'b1;
            S_WAIT:  idle_cycle = 1'b1;
            S_ICYC:  idle_cycle = 1'b1;
            S_CCYC:  cp_cycle   = 1'b1;
            S_IDLE, S_REPORT: ;
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_REPORT);
    assign status   = status_q;
    assign exc_code = exc_q;

    assert_first_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op_legal && !int_fault) |=> cp_phase == PH_FIRST);

    assert_idle_before_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == PH_BUSY) |-> $past(idle_cycle));

    assert_intr_abandons_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == PH_INTR) |=> (done && status == ST_ABANDON));

    assert_reset_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cycle && cp_phase == PH_IDLE && state == S_WAIT && reset_req)
        |=> (cp_phase == PH_INTR && exc_code == EXC_RESET));

    assert_write_in_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && cp_phase == PH_DATA));

    assert_no_mem_regops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cp_cycle |-> !mem_req);
endmodule

// File: tb/cp_handshake_seq_tb_top.sv
`timescale 1ns/1ps
module cp_handshake_seq_tb_top;
    import cphs_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic [31:0] base_addr = '0;
    logic        addr_fault = 1'b0;
    logic [2:0]  cp_phase;
    logic [1:0]  cp_resp;
    logic        reset_req = 1'b0, fiq_req = 1'b0, fiq_mask = 1'b0;
    logic        irq_req = 1'b0, irq_mask = 1'b0;
    logic        mem_req, mem_we, mem_abort;
    logic [31:0] mem_addr;
    logic        idle_cycle, cp_cycle, busy, done;
    logic [2:0]  status;
    logic [1:0]  exc_code;

    always #2.5 clk = ~clk;

    cp_handshake_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
        .base_addr(base_addr), .addr_fault(addr_fault), .cp_phase(cp_phase),
        .cp_resp(cp_resp), .reset_req(reset_req), .fiq_req(fiq_req),
        .fiq_mask(fiq_mask), .irq_req(irq_req), .irq_mask(irq_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_abort(mem_abort), .idle_cycle(idle_cycle), .cp_cycle(cp_cycle),
        .busy(busy), .done(done), .status(status), .exc_code(exc_code)
    );

    // coprocessor model
    int busy_left = 0;
    int inc_left  = 0;
    bit cant_en   = 1'b0;
    bit abort_en  = 1'b0;
    logic [31:0] abort_addr = '0;

    always_comb begin
        cp_resp = RSP_DONE;
        if (cp_phase == PH_FIRST || cp_phase == PH_BUSY)
            cp_resp = cant_en ? RSP_CANT : (busy_left > 0 ? RSP_BUSY : RSP_DONE);
        else if (cp_phase == PH_DATA)
            cp_resp = (inc_left > 0) ? RSP_INC : RSP_DONE;
    end

    always @(posedge clk) begin
        if ((cp_phase == PH_FIRST || cp_phase == PH_BUSY) && !cant_en && busy_left > 0)
            busy_left <= busy_left - 1;
        if (cp_phase == PH_DATA && inc_left > 0)
            inc_left <= inc_left - 1;
    end

    assign mem_abort = abort_en && mem_req && (mem_addr == abort_addr);

    // bookkeeping of one run
    int nvec = 0, nfail = 0;
    int n_first, n_busy, n_intr, n_xfer, n_data, n_idle, n_ccyc, n_mem, n_we, lat;
    bit got_done;
    logic [2:0]  r_status;
    logic [1:0]  r_exc;
    logic [31:0] maddr [16];

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] addr, input bit fault,
                          input int nbusy, input int ninc, input bit cant, input int poke);
        n_first = 0; n_busy = 0; n_intr = 0; n_xfer = 0; n_data = 0;
        n_idle = 0; n_ccyc = 0; n_mem = 0; n_we = 0; lat = 0; got_done = 0;
        r_status = '0; r_exc = '0;
        @(negedge clk);
        busy_left = nbusy; inc_left = ninc; cant_en = cant;
        op_class = op; base_addr = addr; addr_fault = fault; start = 1'b1;
        for (int cyc = 1; cyc < 5000 && !got_done; cyc++) begin
            @(negedge clk);
            start = (cyc == poke);
            if (cyc == poke) begin
                op_class = OP_STORE; base_addr = 32'h0000_4000; addr_fault = 1'b0;
            end
            case (cp_phase)
                PH_FIRST: n_first++;
                PH_BUSY:  n_busy++;
                PH_INTR:  n_intr++;
                PH_XFER:  n_xfer++;
                PH_DATA:  n_data++;
                default: ;
            endcase
            if (idle_cycle) n_idle++;
            if (cp_cycle)   n_ccyc++;
            if (mem_req) begin
                if (n_mem < 16) maddr[n_mem] = mem_addr;
                n_mem++;
                if (mem_we) n_we++;
            end
            if (done) begin
                got_done = 1'b1; r_status = status; r_exc = exc_code; lat = cyc;
            end
        end
        start = 1'b0;
        chk("R2", "instruction reached done", int'(got_done), 1);
    endtask

    task automatic t_reset();
        chk("R1", "phase after reset", int'(cp_phase), int'(PH_IDLE));
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "mem_req after reset", int'(mem_req | mem_we), 0);
    endtask

    task automatic t_plain();
        run_op(OP_DATA, 32'h100, 0, 0, 0, 0, 0);
        chk("R2", "data op FIRST count", n_first, 1);
        chk("R2", "data op latency", lat, 2);
        chk("R10", "data op status", int'(r_status), int'(ST_OK));
        chk("R10", "data op cp/idle cycles", n_ccyc + n_idle + n_mem, 0);
    endtask

    task automatic t_busy_wait();
        run_op(OP_DATA, 32'h100, 0, 3, 0, 0, 0);
        chk("R3", "BUSY phases reissued", n_busy, 3);
        chk("R3", "idle cycles inserted", n_idle, 3);
        chk("R3", "busy-wait latency", lat, 8);
        chk("R3", "busy-wait status", int'(r_status), int'(ST_OK));
    endtask

    task automatic t_ignore_start();
        run_op(OP_DATA, 32'h100, 0, 4, 0, 0, 3);
        chk("R2", "stray start: one FIRST", n_first, 1);
        chk("R2", "stray start: no memory write", n_mem, 0);
        chk("R2", "stray start: status", int'(r_status), int'(ST_OK));
        @(negedge clk);
        chk("R2", "stray start: idle afterwards", int'(busy), 0);
    endtask

    task automatic t_regxfer();
        run_op(OP_TO_CORE, 32'h0, 0, 0, 0, 0, 0);
        chk("R10", "to-core coprocessor cycles", n_ccyc, 1);
        chk("R10", "to-core idle cycles", n_idle, 1);
        chk("R10", "to-core latency", lat, 4);
        run_op(OP_TO_CP, 32'h0, 0, 0, 0, 0, 0);
        chk("R10", "to-cp coprocessor cycles", n_ccyc, 1);
        chk("R10", "to-cp idle cycles", n_idle, 0);
        chk("R10", "to-cp latency", lat, 3);
        chk("R10", "to-cp memory accesses", n_mem, 0);
    endtask

    task automatic t_cant();
        run_op(OP_TO_CP, 32'h0, 0, 0, 0, 1, 0);
        chk("R6", "reg CANT status", int'(r_status), int'(ST_UNDEF));
        chk("R6", "reg CANT coprocessor cycles", n_ccyc, 0);
        run_op(OP_LOAD, 32'h1000, 0, 0, 0, 1, 0);
        chk("R6", "load CANT status", int'(r_status), int'(ST_CP_ABORT));
        chk("R6", "load CANT memory accesses", n_mem, 0);
        cant_en = 1'b0;
    endtask

    task automatic t_intr();
        irq_req = 1'b1;
        run_op(OP_DATA, 32'h0, 0, 5, 0, 0, 0);
        chk("R4", "abandon status", int'(r_status), int'(ST_ABANDON));
        chk("R4", "INTERRUPT phase count", n_intr, 1);
        chk("R4", "no BUSY reissue", n_busy, 0);
        chk("R4", "exception code IRQ", int'(r_exc), int'(EXC_IRQ));
        run_op(OP_DATA, 32'h0, 0, 0, 0, 0, 0);
        chk("R4", "irq without wait: status", int'(r_status), int'(ST_OK));
        chk("R4", "irq without wait: no INTERRUPT", n_intr, 0);
        irq_req = 1'b0;
        busy_left = 0;
    endtask

    task automatic t_prio();
        reset_req = 1'b1; fiq_req = 1'b1; irq_req = 1'b1;
        run_op(OP_DATA, 32'h0, 0, 2, 0, 0, 0);
        chk("R5", "reset wins", int'(r_exc), int'(EXC_RESET));
        reset_req = 1'b0;
        run_op(OP_DATA, 32'h0, 0, 2, 0, 0, 0);
        chk("R5", "fiq over irq", int'(r_exc), int'(EXC_FIQ));
        fiq_mask = 1'b1;
        run_op(OP_DATA, 32'h0, 0, 2, 0, 0, 0);
        chk("R5", "masked fiq gives irq", int'(r_exc), int'(EXC_IRQ));
        irq_mask = 1'b1;
        run_op(OP_DATA, 32'h0, 0, 2, 0, 0, 0);
        chk("R5", "all masked: completes", int'(r_status), int'(ST_OK));
        chk("R5", "all masked: BUSY phases", n_busy, 2);
        fiq_req = 1'b0; irq_req = 1'b0; fiq_mask = 1'b0; irq_mask = 1'b0;
        busy_left = 0;
    endtask

    task automatic t_load();
        run_op(OP_LOAD, 32'h1000, 0, 0, 2, 0, 0);
        chk("R8", "load status", int'(r_status), int'(ST_OK));
        chk("R8", "TRANSFER phases", n_xfer, 1);
        chk("R8", "DATA phases", n_data, 3);
        chk("R8", "words read", n_mem, 3);
        chk("R8", "no writes on load", n_we, 0);
        for (int i = 0; i < 3; i++)
            chk("R8", "load word address", int'(maddr[i]), 32'h1000 + 4 * i);
    endtask

    task automatic t_store();
        run_op(OP_STORE, 32'h2000, 0, 1, 3, 0, 0);
        chk("R9", "store status", int'(r_status), int'(ST_OK));
        chk("R9", "words written", n_we, 4);
        chk("R9", "DATA phases", n_data, 4);
        chk("R9", "no TRANSFER on store", n_xfer, 0);
        for (int i = 0; i < 4; i++)
            chk("R9", "store word address", int'(maddr[i]), 32'h2000 + 4 * i);
    endtask

    task automatic t_int_abort();
        run_op(OP_LOAD, 32'h1000, 1, 0, 0, 0, 0);
        chk("R7", "faulty load status", int'(r_status), int'(ST_INT_ABORT));
        chk("R7", "faulty load no FIRST", n_first, 0);
        chk("R7", "faulty load no access", n_mem, 0);
        run_op(OP_STORE, 32'h10, 0, 0, 0, 0, 0);
        chk("R7", "vector store status", int'(r_status), int'(ST_INT_ABORT));
        chk("R7", "vector store no FIRST", n_first, 0);
        run_op(OP_LOAD, 32'h10, 0, 0, 0, 0, 0);
        chk("R7", "vector load allowed", int'(r_status), int'(ST_OK));
        run_op(OP_STORE, 32'h20, 0, 0, 0, 0, 0);
        chk("R7", "store at limit allowed", int'(r_status), int'(ST_OK));
        chk("R7", "store at limit writes", n_we, 1);
    endtask

    task automatic t_mem_abort();
        abort_en = 1'b1; abort_addr = 32'h3004;
        run_op(OP_LOAD, 32'h3000, 0, 0, 2, 0, 0);
        chk("R12", "load abort status", int'(r_status), int'(ST_MEM_ABORT));
        chk("R12", "load continues after abort", n_mem, 3);
        abort_addr = 32'h5008;
        run_op(OP_STORE, 32'h5000, 0, 0, 2, 0, 0);
        chk("R12", "store abort on last word", int'(r_status), int'(ST_MEM_ABORT));
        chk("R12", "store words", n_we, 3);
        abort_en = 1'b0;
    endtask

    task automatic t_watchdog();
        run_op(OP_DATA, 32'h0, 0, 1023, 0, 0, 0);
        chk("R11", "one below limit completes", int'(r_status), int'(ST_OK));
        run_op(OP_DATA, 32'h0, 0, 2000, 0, 0, 0);
        chk("R11", "limit reached traps", int'(r_status), int'(ST_UNDEF));
        chk("R11", "BUSY phases before trap", n_busy, 1023);
        busy_left = 0;
    endtask

    task automatic t_bad_op();
        run_op(3'd6, 32'h0, 0, 0, 0, 0, 0);
        chk("R13", "unused class status", int'(r_status), int'(ST_UNDEF));
        chk("R13", "unused class no FIRST", n_first, 0);
        chk("R13", "unused class latency", lat, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_plain();
        t_busy_wait();
        t_ignore_start();
        t_regxfer();
        t_cant();
        t_intr();
        t_prio();
        t_load();
        t_store();
        t_int_abort();
        t_mem_abort();
        t_watchdog();
        t_bad_op();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule